// File: doc/BRIEF.md
# Snooping MOSI Line-State Controller

This block keeps the coherence state of every line in one core's private, direct-mapped cache on a shared snooping bus. It accepts one local operation at a time from the core: read, write or evict. It decides whether the operation can finish locally or needs a bus transaction. When the bus is needed, it raises a request and waits for the grant. Each line holds a tag, a two-bit state and one data word.

The same controller also watches every transaction that other cores put on the bus and answers it in the cycle it appears. Depending on the local line state, it invalidates the line, hands its dirty word straight to the requester, or pushes the word back to memory. A mode input picks between two behaviours. In the plain three-state mode, a dirty line that is read by another core is written back. In the four-state mode, the line keeps its dirty data as owner and supplies it cache to cache.

The bus is atomic. In a granted cycle the transaction happens and completes. Fill data for a read arrives on the same cycle. Snoops never share a cycle with this core's own grant.

Top module: `mosi_coherence_ctl`

## Requirements
- R1: After reset every line is Invalid, `coreReady` is 1, and `busReq` and `coreDone` are 0. A snoop then draws no response, and the first read of any address needs the bus.
- R2: A request is taken when `coreValid` and `coreReady` are both 1. `coreReady` stays 0 until the operation ends with a single-cycle `coreDone`, and returns to 1 on the following cycle. While a request waits for its grant and no snoop arrives, the command and address stay stable.
- R3: Bus command codes are ReadToShare=0, ReadToWrite=1, Invalidate=2 and WriteBack=3. Core operation codes are read=0, write=1 and evict=2, and code 3 acts as a read. A read to an Invalid line requests ReadToShare at the request address. It completes in the grant cycle with `coreRData` equal to `busFillData`, and leaves the line Shared.
- R4: A read that hits a Shared, Owner or Modified line completes without a bus request and returns the stored word.
- R5: A write requests ReadToWrite when the line is Invalid or Shared, requests Invalidate when it is Owner, and needs no bus when it is Modified. In every case the line ends Modified and holds the written word.
- R6: Evicting a Modified or Owner line requests WriteBack, carrying the line address and word, and leaves the line Invalid. Evicting a Shared line makes it Invalid without the bus. Evicting an absent line completes at once.
- R7: In three-state mode (`mosiMode`=0), a Modified line that snoops ReadToShare raises `snpFlush` with its word, keeps `snpSupply` at 0, and becomes Shared.
- R8: In four-state mode (`mosiMode`=1), a Modified line that snoops ReadToShare raises `snpSupply` with its word and becomes Owner. An Owner line supplies again on a further ReadToShare and stays Owner.
- R9: A snooped ReadToWrite makes a Modified or Owner line supply its word and go Invalid. A Shared line goes Invalid without a response. A snooped Invalidate makes the line Invalid. A snooped WriteBack changes nothing.
- R10: A snoop whose `snpSrc` equals the core's own ID, whose tag differs from the resident line, or that hits an Invalid line, draws no response and changes no state.
- R11: While a request waits for its grant, snoops are still answered. The command the request needs is re-derived from the line's current state. A write pending on an Owner line changes from Invalidate to ReadToWrite after a snooped ReadToWrite. An eviction pending on a Modified line completes with no bus transaction once a snoop has invalidated the line.
- R12: When a snoop from another core hits the same set in the cycle a bus-free completion would occur, the snoop is applied first and the completion waits one cycle. The operation then re-evaluates against the new state.
- R13: A read or write that misses on a set whose resident line is Modified or Owner with another tag first requests WriteBack of the resident word at the resident address, then its own transaction. A clean resident line is replaced without a write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mosiMode | input | 1 | 1 selects the four-state owner behaviour, 0 the three-state behaviour |
| coreValid | input | 1 | Core presents an operation |
| coreOp | input | 2 | Operation code |
| coreAddr | input | ADDR_W | Operation address |
| coreWData | input | DATA_W | Word to write |
| coreReady | output | 1 | Controller can take an operation |
| coreDone | output | 1 | Operation completes this cycle |
| coreRData | output | DATA_W | Read result, valid with coreDone on reads |
| busReq | output | 1 | Request for the bus |
| busCmd | output | 2 | Command of the requested transaction |
| busAddr | output | ADDR_W | Address of the requested transaction |
| busWData | output | DATA_W | Word carried by a WriteBack |
| busGrant | input | 1 | The requested transaction happens this cycle |
| busFillData | input | DATA_W | Fill word returned during a granted read |
| snpValid | input | 1 | A bus transaction is visible for snooping |
| snpCmd | input | 2 | Snooped command |
| snpAddr | input | ADDR_W | Snooped address |
| snpSrc | input | ID_W | ID of the issuing core |
| snpSupply | output | 1 | This cache drives the data; memory must not |
| snpFlush | output | 1 | This cache writes its dirty word back to memory |
| snpData | output | DATA_W | Word driven for supply or flush |

## Verification
Two functions can collide in one cycle: a local completion that needs no bus, and a snoop from another core on the same set. The bench provokes this by putting a ReadToShare snoop on a Modified line in the first busy cycle of a write hit. It then judges three things. The snoop must return the old word with no completion in that cycle. On the next cycle, the write must ask for Invalidate, because the line is now Owner. A further snoop must see the new word. The pending-grant window is exercised in the same way, by snooping while the grant is held back.

// File: rtl/mosi_pkg.sv
package mosi_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_OWN = 2'd2,
    LS_MOD = 2'd3
  } lineState_t;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_EVICT = 2'd2
  } coreOp_t;

  typedef enum logic [1:0] {
    BUS_RTS = 2'd0,
    BUS_RTW = 2'd1,
    BUS_INV = 2'd2,
    BUS_WB  = 2'd3
  } busCmd_t;

  // strobes from control to the line store
  typedef struct packed {
    logic       take;       // latch a new core request
    logic       coreWr;     // write state/tag of the request set
    lineState_t coreNext;
    logic       loadFill;   // data <= bus fill word
    logic       loadWr;     // data <= request write word
    logic       selVictim;  // bus address is the resident line
    logic       snpWr;      // write state of the snooped set
    lineState_t snpNext;
  } lineStrobe_t;
endpackage

// File: rtl/mosi_line_store.sv
module mosi_line_store
  import mosi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  lineStrobe_t       stb,
  input  logic [1:0]        coreOp,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic [DATA_W-1:0] coreWData,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [DATA_W-1:0] busFillData,
  output logic [1:0]        reqOp,
  output lineState_t        lineState,
  output logic              tagMatch,
  output logic              sameSet,
  output lineState_t        snpState,
  output logic [DATA_W-1:0] snpData,
  output logic [DATA_W-1:0] coreRData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWData
);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqWData;
  lineState_t        lineSt  [NUM_LINES];
  logic [TAG_W-1:0]  lineTag [NUM_LINES];
  logic [DATA_W-1:0] lineDat [NUM_LINES];

  logic [IDX_W-1:0] reqIdx, snpIdx;
  logic [TAG_W-1:0] reqTag, snpTag;

  assign reqIdx = reqAddr[IDX_W-1:0];
  assign reqTag = reqAddr[ADDR_W-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[ADDR_W-1:IDX_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqOp    <= '0;
      reqAddr  <= '0;
      reqWData <= '0;
      for (int i = 0; i < NUM_LINES; i++) lineSt[i] <= LS_INV;
    end else begin
      if (stb.take) begin
        reqOp    <= coreOp;
        reqAddr  <= coreAddr;
        reqWData <= coreWData;
      end
      if (stb.snpWr)  lineSt[snpIdx] <= stb.snpNext;
      if (stb.coreWr) lineSt[reqIdx] <= stb.coreNext;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.coreWr) lineTag[reqIdx] <= reqTag;
    if (stb.loadFill)    lineDat[reqIdx] <= busFillData;
    else if (stb.loadWr) lineDat[reqIdx] <= reqWData;
  end

  assign lineState = lineSt[reqIdx];
  assign tagMatch  = (lineTag[reqIdx] == reqTag);
  assign sameSet   = (snpIdx == reqIdx);
  assign snpState  = (lineSt[snpIdx] != LS_INV && lineTag[snpIdx] == snpTag)
                   ? lineSt[snpIdx] : LS_INV;
  assign snpData   = lineDat[snpIdx];
  assign coreRData = stb.loadFill ? busFillData : lineDat[reqIdx];
  assign busAddr   = stb.selVictim ? {lineTag[reqIdx], reqIdx} : reqAddr;
  assign busWData  = lineDat[reqIdx];
endmodule

// File: rtl/mosi_line_ctrl.sv
module mosi_line_ctrl
  import mosi_pkg::*;
#(
  parameter int ID_W    = 2,
  parameter int CORE_ID = 0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            mosiMode,
  input  logic            coreValid,
  input  logic [1:0]      reqOp,
  input  lineState_t      lineState,
  input  logic            tagMatch,
  input  logic            sameSet,
  input  logic            busGrant,
  input  logic            snpValid,
  input  logic [1:0]      snpCmd,
  input  logic [ID_W-1:0] snpSrc,
  input  lineState_t      snpState,
  output lineStrobe_t     stb,
  output logic            coreReady,
  output logic            coreDone,
  output logic            busReq,
  output logic [1:0]      busCmd,
  output logic            snpSupply,
  output logic            snpFlush
);
  localparam logic [ID_W-1:0] MY_ID = ID_W'(CORE_ID);

  logic       busy;
  logic       snpLive, needBus, localWr, localDone, grantNow;
  lineState_t effState, localNext;
  busCmd_t    cmd;
  logic       victimDirty, selVictim;

  assign snpLive     = snpValid && (snpSrc != MY_ID);
  assign effState    = tagMatch ? lineState : LS_INV;
  assign victimDirty = !tagMatch && (lineState == LS_MOD || lineState == LS_OWN);

  // snoop response
  always_comb begin
    stb.snpWr   = 1'b0;
    stb.snpNext = snpState;
    snpSupply   = 1'b0;
    snpFlush    = 1'b0;
    if (snpLive) begin
      case (busCmd_t'(snpCmd))
        BUS_RTS: begin
          if (snpState == LS_MOD) begin
            stb.snpWr = 1'b1;
            if (mosiMode) begin
              snpSupply   = 1'b1;
              stb.snpNext = LS_OWN;
            end else begin
              snpFlush    = 1'b1;
              stb.snpNext = LS_SHR;
            end
          end else if (snpState == LS_OWN) begin
            snpSupply = 1'b1;
          end
        end
        BUS_RTW: begin
          if (snpState != LS_INV) begin
            stb.snpWr   = 1'b1;
            stb.snpNext = LS_INV;
            snpSupply   = (snpState == LS_MOD || snpState == LS_OWN);
          end
        end
        BUS_INV: begin
          if (snpState != LS_INV) begin
            stb.snpWr   = 1'b1;
            stb.snpNext = LS_INV;
          end
        end
        default: ;
      endcase
    end
  end

  // request decision, re-derived every cycle from the current line state
  always_comb begin
    needBus   = 1'b0;
    cmd       = BUS_RTS;
    selVictim = 1'b0;
    localWr   = 1'b0;
    localNext = effState;
    case (reqOp)
      OP_WRITE: begin
        if (victimDirty) begin
          needBus = 1'b1; cmd = BUS_WB; selVictim = 1'b1;
        end else if (effState == LS_MOD) begin
          localWr = 1'b1; localNext = LS_MOD;
        end else if (effState == LS_OWN) begin
          needBus = 1'b1; cmd = BUS_INV;
        end else begin
          needBus = 1'b1; cmd = BUS_RTW;
        end
      end
      OP_EVICT: begin
        if (effState == LS_MOD || effState == LS_OWN) begin
          needBus = 1'b1; cmd = BUS_WB;
        end else if (effState == LS_SHR) begin
          localWr = 1'b1; localNext = LS_INV;
        end
      end
      default: begin
        if (victimDirty) begin
          needBus = 1'b1; cmd = BUS_WB; selVictim = 1'b1;
        end else if (effState == LS_INV) begin
          needBus = 1'b1; cmd = BUS_RTS;
        end
      end
    endcase
  end

  assign grantNow  = busy && needBus && busGrant;
  assign localDone = busy && !needBus && !(snpLive && sameSet);
  assign coreDone  = localDone || (grantNow && !selVictim);
  assign coreReady = !busy;
  assign busReq    = busy && needBus;
  assign busCmd    = cmd;

  always_comb begin
    stb.take      = coreValid && !busy;
    stb.selVictim = selVictim;
    stb.coreWr    = (localDone && localWr) || grantNow;
    if (grantNow)
      stb.coreNext = (cmd == BUS_WB) ? LS_INV : (cmd == BUS_RTS) ? LS_SHR : LS_MOD;
    else
      stb.coreNext = localNext;
    stb.loadFill  = grantNow && (cmd == BUS_RTS);
    stb.loadWr    = stb.coreWr && (stb.coreNext == LS_MOD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          busy <= 1'b0;
    else if (stb.take)  busy <= 1'b1;
    else if (coreDone)  busy <= 1'b0;
  end
endmodule

// File: rtl/mosi_coherence_ctl.sv
module mosi_coherence_ctl
  import mosi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 16,
  parameter int ID_W      = 2,
  parameter int CORE_ID   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mosiMode,
  input  logic              coreValid,
  input  logic [1:0]        coreOp,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic [DATA_W-1:0] coreWData,
  output logic              coreReady,
  output logic              coreDone,
  output logic [DATA_W-1:0] coreRData,
  output logic              busReq,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWData,
  input  logic              busGrant,
  input  logic [DATA_W-1:0] busFillData,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [ID_W-1:0]   snpSrc,
  output logic              snpSupply,
  output logic              snpFlush,
  output logic [DATA_W-1:0] snpData
);
  lineStrobe_t stb;
  lineState_t  lineState, snpState;
  logic        tagMatch, sameSet;
  logic [1:0]  reqOp;

  mosi_line_store #(
    .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) uStore (
    .clk(clk), .rstN(rstN), .stb(stb),
    .coreOp(coreOp), .coreAddr(coreAddr), .coreWData(coreWData),
    .snpAddr(snpAddr), .busFillData(busFillData),
    .reqOp(reqOp), .lineState(lineState), .tagMatch(tagMatch),
    .sameSet(sameSet), .snpState(snpState), .snpData(snpData),
    .coreRData(coreRData), .busAddr(busAddr), .busWData(busWData)
  );

  mosi_line_ctrl #(
    .ID_W(ID_W), .CORE_ID(CORE_ID)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .mosiMode(mosiMode),
    .coreValid(coreValid), .reqOp(reqOp), .lineState(lineState),
    .tagMatch(tagMatch), .sameSet(sameSet), .busGrant(busGrant),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpSrc(snpSrc),
    .snpState(snpState), .stb(stb), .coreReady(coreReady),
    .coreDone(coreDone), .busReq(busReq), .busCmd(busCmd),
    .snpSupply(snpSupply), .snpFlush(snpFlush)
  );
endmodule

// File: rtl/mosi_line_chk.sv
module mosi_line_chk #(
  parameter int ADDR_W  = 12,
  parameter int ID_W    = 2,
  parameter int CORE_ID = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              mosiMode,
  input logic              coreReady,
  input logic              coreDone,
  input logic              busReq,
  input logic              busGrant,
  input logic [1:0]        busCmd,
  input logic [ADDR_W-1:0] busAddr,
  input logic              snpValid,
  input logic [1:0]        snpCmd,
  input logic [ID_W-1:0]   snpSrc,
  input logic              snpSupply,
  input logic              snpFlush
);
  localparam logic [ID_W-1:0] MY_ID = ID_W'(CORE_ID);

  a_r2_done_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    coreDone |-> !coreReady);

  a_r2_ready_after_done: assert property (@(posedge clk) disable iff (!rstN)
    coreDone |=> (coreReady && !coreDone));

  a_r2_request_held: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGrant && !snpValid) |=>
      (busReq && $stable(busCmd) && $stable(busAddr)));

  a_r7_flush_only_msi: assert property (@(posedge clk) disable iff (!rstN)
    snpFlush |-> (snpValid && !mosiMode && snpCmd == 2'd0));

  a_r8_single_response: assert property (@(posedge clk) disable iff (!rstN)
    !(snpSupply && snpFlush));

  a_r9_supply_on_reads: assert property (@(posedge clk) disable iff (!rstN)
    snpSupply |-> (snpValid && (snpCmd == 2'd0 || snpCmd == 2'd1)));

  a_r10_own_src_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpSrc == MY_ID) |-> !(snpSupply || snpFlush));

  a_r11_atomic_bus: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busGrant) |-> !snpValid);
endmodule

bind mosi_coherence_ctl mosi_line_chk #(
  .ADDR_W(ADDR_W), .ID_W(ID_W), .CORE_ID(CORE_ID)
) uChk (
  .clk(clk), .rstN(rstN), .mosiMode(mosiMode), .coreReady(coreReady),
  .coreDone(coreDone), .busReq(busReq), .busGrant(busGrant),
  .busCmd(busCmd), .busAddr(busAddr), .snpValid(snpValid),
  .snpCmd(snpCmd), .snpSrc(snpSrc), .snpSupply(snpSupply),
  .snpFlush(snpFlush)
);

// File: tb/tb_mosi_coherence_ctl.sv
module tb_mosi_coherence_ctl;
  localparam logic [1:0] RD = 2'd0, WR = 2'd1, EV = 2'd2;
  localparam logic [1:0] RTS = 2'd0, RTW = 2'd1, INV = 2'd2, WB = 2'd3;

  logic clk = 1'b0, rstN = 1'b0, mosiMode = 1'b1;
  logic coreValid = 1'b0;
  logic [1:0] coreOp = '0;
  logic [11:0] coreAddr = '0;
  logic [15:0] coreWData = '0;
  logic coreReady, coreDone;
  logic [15:0] coreRData;
  logic busReq;
  logic [1:0] busCmd;
  logic [11:0] busAddr;
  logic [15:0] busWData;
  logic busGrant = 1'b0;
  logic [15:0] busFillData = '0;
  logic snpValid = 1'b0;
  logic [1:0] snpCmd = '0;
  logic [11:0] snpAddr = '0;
  logic [1:0] snpSrc = '0;
  logic snpSupply, snpFlush;
  logic [15:0] snpData;

  int nChk = 0, nBad = 0;

  always #4 clk = ~clk;

  mosi_coherence_ctl dut (
    .clk(clk), .rstN(rstN), .mosiMode(mosiMode),
    .coreValid(coreValid), .coreOp(coreOp), .coreAddr(coreAddr),
    .coreWData(coreWData), .coreReady(coreReady), .coreDone(coreDone),
    .coreRData(coreRData), .busReq(busReq), .busCmd(busCmd),
    .busAddr(busAddr), .busWData(busWData), .busGrant(busGrant),
    .busFillData(busFillData), .snpValid(snpValid), .snpCmd(snpCmd),
    .snpAddr(snpAddr), .snpSrc(snpSrc), .snpSupply(snpSupply),
    .snpFlush(snpFlush), .snpData(snpData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [11:0] addr;
    logic [15:0] wd;
    logic [15:0] fill;
    logic [1:0]  nBus;
    logic [1:0]  cmd;
    logic [15:0] expData;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VEC [NVEC] = '{
    '{RD, 12'h010, 16'h0000, 16'h1111, 2'd1, RTS, 16'h1111},
    '{RD, 12'h010, 16'h0000, 16'h0000, 2'd0, RTS, 16'h1111},
    '{WR, 12'h010, 16'h2222, 16'h0000, 2'd1, RTW, 16'h0000},
    '{WR, 12'h010, 16'h3333, 16'h0000, 2'd0, RTS, 16'h0000},
    '{RD, 12'h010, 16'h0000, 16'h0000, 2'd0, RTS, 16'h3333},
    '{WR, 12'h021, 16'h4444, 16'h0000, 2'd1, RTW, 16'h0000},
    '{EV, 12'h021, 16'h0000, 16'h0000, 2'd1, WB,  16'h4444},
    '{EV, 12'h021, 16'h0000, 16'h0000, 2'd0, RTS, 16'h0000},
    '{RD, 12'h021, 16'h0000, 16'h5555, 2'd1, RTS, 16'h5555},
    '{EV, 12'h021, 16'h0000, 16'h0000, 2'd0, RTS, 16'h0000},
    '{RD, 12'h021, 16'h0000, 16'h6666, 2'd1, RTS, 16'h6666}
  };

  // one full operation with an immediate grant to every bus request
  task automatic runOp(input logic [1:0] op, input logic [11:0] a,
                       input logic [15:0] wd, input logic [15:0] fill,
                       output int nb, output logic [1:0] c0, output logic [11:0] a0,
                       output logic [15:0] d0, output logic [1:0] c1,
                       output logic [11:0] a1, output logic [15:0] rd);
    bit fin;
    fin = 0; nb = 0; c0 = '0; a0 = '0; d0 = '0; c1 = '0; a1 = '0; rd = '0;
    @(negedge clk);
    coreValid = 1'b1; coreOp = op; coreAddr = a; coreWData = wd;
    @(negedge clk);
    coreValid = 1'b0;
    for (int k = 0; k < 20 && !fin; k++) begin
      #1;
      if (busReq) begin
        if (nb == 0) begin c0 = busCmd; a0 = busAddr; d0 = busWData; end
        else begin c1 = busCmd; a1 = busAddr; end
        nb++;
        busGrant = 1'b1; busFillData = fill;
        #1;
      end
      if (coreDone) begin fin = 1; rd = coreRData; end
      @(negedge clk);
      busGrant = 1'b0;
    end
  endtask

  task automatic snoop(input logic [1:0] c, input logic [11:0] a, input logic [1:0] src,
                       output logic sup, output logic fl, output logic [15:0] d);
    @(negedge clk);
    snpValid = 1'b1; snpCmd = c; snpAddr = a; snpSrc = src;
    #1;
    sup = snpSupply; fl = snpFlush; d = snpData;
    @(posedge clk);
    #1 snpValid = 1'b0;
  endtask

  task automatic startOp(input logic [1:0] op, input logic [11:0] a, input logic [15:0] wd);
    @(negedge clk);
    coreValid = 1'b1; coreOp = op; coreAddr = a; coreWData = wd;
    @(negedge clk);
    coreValid = 1'b0;
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", nChk, nBad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=hang expected=finish");
    summary();
    $finish;
  end

  initial begin
    int nb;
    logic [1:0] c0, c1;
    logic [11:0] a0, a1;
    logic [15:0] d0, rd, sd;
    logic sup, fl;

    repeat (3) @(negedge clk);
    #1;
    chk("R1 ready in reset-exit", {31'd0, coreReady}, 1);
    chk("R1 no busReq", {31'd0, busReq}, 0);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk("R1 no done", {31'd0, coreDone}, 0);
    snoop(RTW, 12'h010, 2'd1, sup, fl, sd);
    chk("R1 snoop on empty cache", {30'd0, sup, fl}, 0);

    // table walk, four-state mode
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      vec_t v;
      v = VEC[i];
      tag = (v.op == WR) ? "R5" : (v.op == EV) ? "R6" : (v.nBus == 0) ? "R4" : "R3";
      runOp(v.op, v.addr, v.wd, v.fill, nb, c0, a0, d0, c1, a1, rd);
      chk({tag, " bus count"}, nb, v.nBus);
      if (v.nBus != 0) begin
        chk({tag, " bus cmd"}, c0, v.cmd);
        chk({tag, " bus addr"}, a0, v.addr);
        if (v.cmd == WB) chk({tag, " writeback word"}, d0, v.expData);
      end
      if (v.op == RD) chk({tag, " read data"}, rd, v.expData);
      chk("R2 ready after op", {31'd0, coreReady}, 1);
    end

    // R8: Modified -> Owner supplies, Owner supplies again
    snoop(RTS, 12'h010, 2'd1, sup, fl, sd);
    chk("R8 M supply", {30'd0, sup, fl}, 2);
    chk("R8 M supply word", sd, 16'h3333);
    snoop(RTS, 12'h010, 2'd1, sup, fl, sd);
    chk("R8 O supplies again", {30'd0, sup, fl}, 2);
    runOp(WR, 12'h010, 16'h7777, 0, nb, c0, a0, d0, c1, a1, rd);
    chk("R5 write on Owner uses Invalidate", c0, INV);

    // R10: ignored snoops
    snoop(RTS, 12'h010, 2'd0, sup, fl, sd);
    chk("R10 own src quiet", {30'd0, sup, fl}, 0);
    snoop(RTW, 12'h810, 2'd1, sup, fl, sd);
    chk("R10 tag mismatch quiet", {30'd0, sup, fl}, 0);
    runOp(WR, 12'h010, 16'h7788, 0, nb, c0, a0, d0, c1, a1, rd);
    chk("R10 line still Modified", nb, 0);

    // R9
    snoop(RTW, 12'h010, 2'd1, sup, fl, sd);
    chk("R9 M on RTW supplies", {30'd0, sup, fl}, 2);
    chk("R9 supplied word", sd, 16'h7788);
    snoop(RTS, 12'h010, 2'd1, sup, fl, sd);
    chk("R9 line now Invalid", {30'd0, sup, fl}, 0);
    runOp(RD, 12'h010, 0, 16'h9999, nb, c0, a0, d0, c1, a1, rd);
    chk("R9 reread misses", nb, 1);
    snoop(RTW, 12'h010, 2'd2, sup, fl, sd);
    chk("R9 S on RTW silent", {30'd0, sup, fl}, 0);
    runOp(RD, 12'h010, 0, 16'h9A9A, nb, c0, a0, d0, c1, a1, rd);
    chk("R9 S invalidated by RTW", nb, 1);
    snoop(WB, 12'h010, 2'd1, sup, fl, sd);
    runOp(RD, 12'h010, 0, 0, nb, c0, a0, d0, c1, a1, rd);
    chk("R9 WB snoop no effect", nb, 0);
    chk("R9 WB snoop keeps word", rd, 16'h9A9A);
    snoop(INV, 12'h021, 2'd1, sup, fl, sd);
    runOp(RD, 12'h021, 0, 16'h1357, nb, c0, a0, d0, c1, a1, rd);
    chk("R9 Invalidate snoop clears S", nb, 1);

    // R7: three-state mode write-back on shared read
    mosiMode = 1'b0;
    runOp(WR, 12'h010, 16'hAAAA, 0, nb, c0, a0, d0, c1, a1, rd);
    chk("R5 write on Shared uses RTW", c0, RTW);
    snoop(RTS, 12'h010, 2'd2, sup, fl, sd);
    chk("R7 flush not supply", {30'd0, sup, fl}, 1);
    chk("R7 flush word", sd, 16'hAAAA);
    runOp(WR, 12'h010, 16'hBBBB, 0, nb, c0, a0, d0, c1, a1, rd);
    chk("R7 line went Shared", c0, RTW);

    // R13: dirty victim then own fill; clean victim dropped
    runOp(RD, 12'h810, 0, 16'hCCCC, nb, c0, a0, d0, c1, a1, rd);
    chk("R13 two transactions", nb, 2);
    chk("R13 victim WB", c0, WB);
    chk("R13 victim addr", a0, 12'h010);
    chk("R13 victim word", d0, 16'hBBBB);
    chk("R13 then RTS", c1, RTS);
    chk("R13 then own addr", a1, 12'h810);
    chk("R13 fill word", rd, 16'hCCCC);
    runOp(RD, 12'h010, 0, 16'hDDDD, nb, c0, a0, d0, c1, a1, rd);
    chk("R13 clean victim no WB", nb, 1);

    // R11: re-evaluation while waiting for grant
    mosiMode = 1'b1;
    runOp(WR, 12'h010, 16'h0E0E, 0, nb, c0, a0, d0, c1, a1, rd);
    snoop(RTS, 12'h010, 2'd1, sup, fl, sd);
    startOp(WR, 12'h010, 16'h0F0F);
    #1;
    chk("R11 pending Invalidate", {29'd0, busReq, busCmd}, {29'd0, 1'b1, INV});
    chk("R2 busy not ready", {31'd0, coreReady}, 0);
    @(negedge clk); #1;
    chk("R2 request held", {29'd0, busReq, busCmd}, {29'd0, 1'b1, INV});
    snpValid = 1'b1; snpCmd = RTW; snpAddr = 12'h010; snpSrc = 2'd1;
    #1;
    chk("R11 snoop answered while pending", {15'd0, snpSupply, snpData}, {15'd0, 1'b1, 16'h0E0E});
    @(negedge clk);
    snpValid = 1'b0;
    #1;
    chk("R11 pending now RTW", {29'd0, busReq, busCmd}, {29'd0, 1'b1, RTW});
    busGrant = 1'b1;
    #1;
    chk("R11 done on grant", {31'd0, coreDone}, 1);
    @(negedge clk);
    busGrant = 1'b0;
    #1;
    chk("R2 ready again", {31'd0, coreReady}, 1);

    startOp(EV, 12'h010, 0);
    #1;
    chk("R11 pending WB", {29'd0, busReq, busCmd}, {29'd0, 1'b1, WB});
    snpValid = 1'b1; snpCmd = RTW; snpAddr = 12'h010; snpSrc = 2'd3;
    #1;
    chk("R11 snoop supplies M", {31'd0, snpSupply}, 1);
    @(negedge clk);
    snpValid = 1'b0;
    #1;
    chk("R11 evict done without bus", {30'd0, busReq, coreDone}, 1);
    @(negedge clk);

    // R12: same-set snoop beside a bus-free write hit
    runOp(WR, 12'h010, 16'h1234, 0, nb, c0, a0, d0, c1, a1, rd);
    chk("R12 setup RTW", c0, RTW);
    startOp(WR, 12'h010, 16'h5678);
    snpValid = 1'b1; snpCmd = RTS; snpAddr = 12'h010; snpSrc = 2'd1;
    #1;
    chk("R12 completion deferred", {31'd0, coreDone}, 0);
    chk("R12 old word supplied", {15'd0, snpSupply, snpData}, {15'd0, 1'b1, 16'h1234});
    @(negedge clk);
    snpValid = 1'b0;
    #1;
    chk("R12 now needs Invalidate", {29'd0, busReq, busCmd}, {29'd0, 1'b1, INV});
    busGrant = 1'b1;
    #1;
    chk("R12 done on grant", {31'd0, coreDone}, 1);
    @(negedge clk);
    busGrant = 1'b0;
    snoop(RTW, 12'h010, 2'd1, sup, fl, sd);
    chk("R12 new word held", sd, 16'h5678);

    summary();
    $finish;
  end
endmodule